// File: doc/BRIEF.md
# Serial Nibble Register Access Port

This block is the slave side of a three-wire host link: a select line, a shift clock and a single data line. It gives a host access to a bank of sixteen 4-bit registers. The register bank sits outside the block. The block only drives the bank's address, write strobe, write data and per-bit write enable, and it takes back the read data for the current address. The select, shift-clock and data pins arrive asynchronously. A two-stage synchronizer on the much faster system clock samples them, and each rising shift-clock edge is detected in that clock domain.

While select is high, the host sends nibbles least significant bit first. The first nibble picks the transfer kind. The second nibble gives a starting address. Every later nibble is either written to the bank or read out of it, and the address steps forward by one after each nibble, rolling over from the top of the bank to zero. For a read, the block takes over the data line after the address nibble. Two register side effects come out as one-cycle strobes. One marks a completed read of the control register that holds the interrupt flag. The other marks the end of a selection, so the bank can clear its self-clearing bits.

Top module: `nibble_regif`

## Requirements
- R1: With select high, the bit present on the data line at each rising shift-clock edge is taken in LSB first. A first nibble of 0x3 starts a write. Each data nibble after the address nibble produces one `rf_we` pulse carrying that nibble on `rf_wdata`, at the address on `rf_addr`.
- R2: The first data nibble uses the address given in the second nibble. Each completed data nibble, written or read, advances the address by one, and 0xF is followed by 0x0.
- R3: A first nibble of 0xC starts a read. `host_doe` rises after the eighth rising edge and stays high until select falls. Bit 0 of the addressed register is driven first. Each later rising edge moves to the next bit, so the host samples bit k before edge 9+k. After four bits the next address follows.
- R4: Any first nibble other than 0x3 or 0xC leaves `host_doe` low and produces no `rf_we` and no strobe until select falls.
- R5: When select falls with fewer than four bits of a nibble taken, that nibble causes no write and no read strobe. Nibbles completed earlier in the same selection keep their effect. A rising edge that reaches the block in the same cycle as the select fall does not count.
- R6: While select is low, `host_doe` is low and shift-clock edges have no effect.
- R7: Each fall of select produces exactly one one-cycle pulse on `desel_pulse`.
- R8: `irqf_clear` pulses for one cycle when the fourth bit of a read of address 0xD is taken. Reads of other addresses and partial reads of 0xD do not pulse it.
- R9: A write to address 0xD carries `rf_wmask` = 0xB, so bit 2 (the interrupt flag) is never written. Writes to any other address carry `rf_wmask` = 0xF.
- R10: During and right after reset, `host_doe`, `rf_we`, `irqf_clear` and `desel_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Select from the host, high while a transfer is active |
| host_sck | input | 1 | Shift clock from the host |
| host_din | input | 1 | Data line value as seen at the pin |
| host_dout | output | 1 | Data line value driven during reads |
| host_doe | output | 1 | Output enable for the data line pad |
| rf_addr | output | NIB_W | Register bank address |
| rf_we | output | 1 | One-cycle write strobe to the register bank |
| rf_wdata | output | NIB_W | Write data for the register bank |
| rf_wmask | output | NIB_W | Per-bit write enable, 1 = bit is written |
| rf_rdata | input | NIB_W | Register bank read data for `rf_addr` |
| irqf_clear | output | 1 | Pulse: a read of the interrupt-flag register completed |
| desel_pulse | output | 1 | Pulse: select has just fallen |

## Verification
The completion of a nibble and a deselect can fall in the same synchronized cycle. The bench provokes this by raising the shift clock and dropping select at the same instant, on the fourth bit of a write nibble and again on the fourth bit of a read of 0xD. Both pins pass through the same synchronizer stages, so the edge and the select fall reach the control logic together. The outcome is judged at the ports. The register contents must be unchanged, the count of `irqf_clear` pulses must not grow, and exactly one `desel_pulse` must appear, which shows that deselect takes priority.

// File: rtl/nrif_pkg.sv
`timescale 1ns/1ps
package nrif_pkg;

    localparam int unsigned NIB_W_DEF    = 4;
    localparam int unsigned SYNC_DEF     = 2;
    localparam int unsigned WR_CODE_DEF  = 3;
    localparam int unsigned RD_CODE_DEF  = 12;
    localparam int unsigned IRQ_ADDR_DEF = 13;
    localparam int unsigned IRQ_BIT_DEF  = 2;

    // Pins as seen from the host side, kept together through the synchronizer
    typedef struct packed {
        logic sel;
        logic sck;
        logic din;
    } pins_t;

    // Where the transfer stands inside one selection
    typedef enum logic [2:0] {
        PH_MODE,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_DEAD
    } phase_e;

    typedef enum logic [1:0] {
        XF_NONE,
        XF_WRITE,
        XF_READ
    } xfer_e;

    function automatic xfer_e decode_mode(input int unsigned code,
                                          input int unsigned wr_code,
                                          input int unsigned rd_code);
        if (code == wr_code) return XF_WRITE;
        if (code == rd_code) return XF_READ;
        return XF_NONE;
    endfunction

endpackage

// File: rtl/nrif_sync.sv
`timescale 1ns/1ps
module nrif_sync
    import nrif_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t raw,
    output pins_t synced
);

    pins_t stage_q [STAGES];

    generate
        for (genvar i = 0; i < int'(STAGES); i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= '0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[STAGES-1];

endmodule

// File: rtl/nrif_edge.sv
`timescale 1ns/1ps
module nrif_edge
    import nrif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t cur,
    output logic  sck_rise,
    output logic  sel_fall,
    output logic  sel_on,
    output logic  din
);

    logic sck_prev_q;
    logic sel_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev_q <= 1'b0;
            sel_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= cur.sck;
            sel_prev_q <= cur.sel;
        end
    end

    // A shift-clock edge only counts while the synchronized select is high
    assign sck_rise = cur.sck & ~sck_prev_q & cur.sel;
    assign sel_fall = ~cur.sel & sel_prev_q;
    assign sel_on   = cur.sel;
    assign din      = cur.din;

    p_fall_single_r7: assert property (@(posedge clk) disable iff (rst)
        sel_fall |=> !sel_fall);

endmodule

// File: rtl/nrif_shift.sv
`timescale 1ns/1ps
module nrif_shift #(
    parameter int unsigned NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_en,
    input  logic             din,
    output logic             nib_done,
    output logic [NIB_W-1:0] nib_val
);

    localparam int unsigned CNT_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [NIB_W-2:0] sh_q;

    // Newest bit enters at the top, so the first bit ends up as bit 0
    assign nib_val  = {din, sh_q};
    assign nib_done = bit_en && (cnt_q == CNT_W'(NIB_W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (bit_en) begin
            cnt_q <= nib_done ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else if (bit_en) sh_q <= nib_val[NIB_W-1:1];
    end

    p_cnt_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/nrif_ctrl.sv
`timescale 1ns/1ps
module nrif_ctrl
    import nrif_pkg::*;
#(
    parameter int unsigned NIB_W    = NIB_W_DEF,
    parameter int unsigned WR_CODE  = WR_CODE_DEF,
    parameter int unsigned RD_CODE  = RD_CODE_DEF,
    parameter int unsigned IRQ_ADDR = IRQ_ADDR_DEF,
    parameter int unsigned IRQ_BIT  = IRQ_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_on,
    input  logic             sel_fall,
    input  logic             sck_rise,
    input  logic             nib_done,
    input  logic [NIB_W-1:0] nib_val,
    input  logic [NIB_W-1:0] rf_rdata,
    output logic [NIB_W-1:0] rf_addr,
    output logic             rf_we,
    output logic [NIB_W-1:0] rf_wdata,
    output logic [NIB_W-1:0] rf_wmask,
    output logic             dout,
    output logic             doe,
    output logic             irq_clr,
    output logic             desel
);

    localparam logic [NIB_W-1:0] FLAG_ADDR = NIB_W'(IRQ_ADDR);

    phase_e           phase_q;
    logic             rd_q;
    logic [NIB_W-1:0] addr_q;
    logic [NIB_W-1:0] osh_q;
    logic             load_q;
    logic             doe_q;
    xfer_e            mode_dec;

    always_comb begin
        mode_dec = decode_mode(32'(nib_val), WR_CODE, RD_CODE);
    end

    always_comb begin
        rf_we    = nib_done && (phase_q == PH_WDATA);
        irq_clr  = nib_done && (phase_q == PH_RDATA) && (addr_q == FLAG_ADDR);
        rf_wmask = '1;
        if (addr_q == FLAG_ADDR) rf_wmask[IRQ_BIT] = 1'b0;
    end

    assign rf_addr  = addr_q;
    assign rf_wdata = nib_val;
    assign doe      = doe_q;
    assign dout     = doe_q & osh_q[0];
    assign desel    = sel_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_MODE;
            rd_q    <= 1'b0;
            addr_q  <= '0;
            osh_q   <= '0;
            load_q  <= 1'b0;
            doe_q   <= 1'b0;
        end else if (!sel_on) begin
            phase_q <= PH_MODE;
            rd_q    <= 1'b0;
            load_q  <= 1'b0;
            doe_q   <= 1'b0;
        end else begin
            load_q <= 1'b0;
            // Output shifter: reload one cycle after the address settles
            if (load_q) begin
                osh_q <= rf_rdata;
            end else if (sck_rise && (phase_q == PH_RDATA) && !nib_done) begin
                osh_q <= osh_q >> 1;
            end
            if (nib_done) begin
                unique case (phase_q)
                    PH_MODE: begin
                        unique case (mode_dec)
                            XF_WRITE: begin phase_q <= PH_ADDR; rd_q <= 1'b0; end
                            XF_READ:  begin phase_q <= PH_ADDR; rd_q <= 1'b1; end
                            default:  phase_q <= PH_DEAD;
                        endcase
                    end
                    PH_ADDR: begin
                        addr_q <= nib_val;
                        if (rd_q) begin
                            phase_q <= PH_RDATA;
                            doe_q   <= 1'b1;
                            load_q  <= 1'b1;
                        end else begin
                            phase_q <= PH_WDATA;
                        end
                    end
                    PH_WDATA: addr_q <= addr_q + 1'b1;
                    PH_RDATA: begin
                        addr_q <= addr_q + 1'b1;
                        load_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    p_we_not_driving_r1: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> !doe_q);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (nib_done && (phase_q == PH_WDATA || phase_q == PH_RDATA))
        |=> (addr_q == $past(addr_q) + 1'b1));

    p_oe_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_on && doe_q) |=> doe_q);

    p_dead_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DEAD) |-> (!rf_we && !doe_q));

    p_doe_off_r6: assert property (@(posedge clk) disable iff (rst)
        !sel_on |=> !doe_q);

    p_clr_in_read_r8: assert property (@(posedge clk) disable iff (rst)
        irq_clr |-> doe_q);

endmodule

// File: rtl/nibble_regif.sv
`timescale 1ns/1ps
module nibble_regif
    import nrif_pkg::*;
#(
    parameter int unsigned NIB_W       = NIB_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF,
    parameter int unsigned WR_CODE     = WR_CODE_DEF,
    parameter int unsigned RD_CODE     = RD_CODE_DEF,
    parameter int unsigned IRQ_ADDR    = IRQ_ADDR_DEF,
    parameter int unsigned IRQ_BIT     = IRQ_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_sel,
    input  logic             host_sck,
    input  logic             host_din,
    output logic             host_dout,
    output logic             host_doe,
    output logic [NIB_W-1:0] rf_addr,
    output logic             rf_we,
    output logic [NIB_W-1:0] rf_wdata,
    output logic [NIB_W-1:0] rf_wmask,
    input  logic [NIB_W-1:0] rf_rdata,
    output logic             irqf_clear,
    output logic             desel_pulse
);

    pins_t            raw_pins;
    pins_t            sync_pins;
    logic             sck_rise;
    logic             sel_fall;
    logic             sel_on;
    logic             din_s;
    logic             nib_done;
    logic [NIB_W-1:0] nib_val;

    assign raw_pins = '{sel: host_sel, sck: host_sck, din: host_din};

    nrif_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_pins),
        .synced (sync_pins)
    );

    nrif_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .cur      (sync_pins),
        .sck_rise (sck_rise),
        .sel_fall (sel_fall),
        .sel_on   (sel_on),
        .din      (din_s)
    );

    nrif_shift #(.NIB_W(NIB_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (!sel_on),
        .bit_en   (sck_rise),
        .din      (din_s),
        .nib_done (nib_done),
        .nib_val  (nib_val)
    );

    nrif_ctrl #(
        .NIB_W    (NIB_W),
        .WR_CODE  (WR_CODE),
        .RD_CODE  (RD_CODE),
        .IRQ_ADDR (IRQ_ADDR),
        .IRQ_BIT  (IRQ_BIT)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel_on   (sel_on),
        .sel_fall (sel_fall),
        .sck_rise (sck_rise),
        .nib_done (nib_done),
        .nib_val  (nib_val),
        .rf_rdata (rf_rdata),
        .rf_addr  (rf_addr),
        .rf_we    (rf_we),
        .rf_wdata (rf_wdata),
        .rf_wmask (rf_wmask),
        .dout     (host_dout),
        .doe      (host_doe),
        .irq_clr  (irqf_clear),
        .desel    (desel_pulse)
    );

endmodule

// File: tb/tb_nibble_regif.sv
`timescale 1ns/1ps
module tb_nibble_regif;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       host_sel = 1'b0;
    logic       host_sck = 1'b0;
    logic       host_din = 1'b0;
    logic       host_dout, host_doe;
    logic [3:0] rf_addr, rf_wdata, rf_wmask, rf_rdata;
    logic       rf_we, irqf_clear, desel_pulse;

    nibble_regif dut (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_sck(host_sck), .host_din(host_din),
        .host_dout(host_dout), .host_doe(host_doe),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .rf_wmask(rf_wmask), .rf_rdata(rf_rdata),
        .irqf_clear(irqf_clear), .desel_pulse(desel_pulse)
    );

    // Register bank around the block, honouring the write mask
    logic [3:0] mem [16];
    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 4'(i * 5 + 2);
        end else if (rf_we) begin
            mem[rf_addr] <= (mem[rf_addr] & ~rf_wmask) | (rf_wdata & rf_wmask);
        end
    end

    // Behavioural model state
    logic [3:0] exp_mem [16];
    logic       exp_oe = 1'b0;
    logic       arm_oe = 1'b0;
    int         exp_we = 0, exp_irq = 0, exp_desel = 0;
    time        t_chg = 0;
    logic [3:0] tx [8];

    int checks = 0, bad = 0;
    int oe_checks = 0, oe_bad = 0;
    int n_we = 0, n_irq = 0, n_desel = 0;
    logic finished = 1'b0;

    // Observed strobes and per-clock enable comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (rf_we) n_we++;
            if (irqf_clear) n_irq++;
            if (desel_pulse) n_desel++;
            if (($time - t_chg) >= 50) begin
                oe_checks++;
                if (host_doe !== exp_oe) begin
                    oe_bad++;
                    if (oe_bad < 8)
                        $display("FAIL R3/R6 host_doe at %0t act=%0b exp=%0b", $time, host_doe, exp_oe);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic put_bit(input logic b, output logic r);
        host_sck = 1'b0;
        host_din = b;
        t_chg = $time;
        wait_cyc(HALF);
        r = host_dout;
        host_sck = 1'b1;
        t_chg = $time;
        if (arm_oe) begin
            exp_oe = 1'b1;
            arm_oe = 1'b0;
        end
        wait_cyc(HALF);
    endtask

    task automatic put_nib(input logic [3:0] v, input logic arm, output logic [3:0] r);
        for (int b = 0; b < 4; b++) begin
            logic rb;
            if (arm && b == 3) arm_oe = 1'b1;
            put_bit(v[b], rb);
            r[b] = rb;
        end
    endtask

    task automatic end_sel();
        host_sel = 1'b0;
        host_sck = 1'b0;
        exp_oe = 1'b0;
        t_chg = $time;
        exp_desel++;
        wait_cyc(10);
    endtask

    task automatic txn(input logic [3:0] mode, input logic [3:0] start,
                       input int n, input int tail);
        logic [3:0] a, r;
        a = start;
        host_sel = 1'b1;
        t_chg = $time;
        wait_cyc(HALF);
        put_nib(mode, 1'b0, r);
        put_nib(start, (mode == 4'hC), r);
        for (int i = 0; i < n; i++) begin
            put_nib(tx[i], 1'b0, r);
            if (mode == 4'h3) begin
                if (a == 4'hD) exp_mem[a] = (exp_mem[a] & 4'h4) | (tx[i] & 4'hB);
                else           exp_mem[a] = tx[i];
                exp_we++;
            end else if (mode == 4'hC) begin
                chk($sformatf("R3 read nibble addr %0h", a), r, exp_mem[a]);
                if (a == 4'hD) exp_irq++;
            end
            a = a + 1'b1;
        end
        for (int t = 0; t < tail; t++) begin
            logic rb;
            put_bit(tx[n][t], rb);
        end
        end_sel();
    endtask

    // Last bit edge and select fall launched together
    task automatic race(input logic [3:0] mode, input logic [3:0] start, input logic [3:0] v);
        logic [3:0] r;
        host_sel = 1'b1;
        t_chg = $time;
        wait_cyc(HALF);
        put_nib(mode, 1'b0, r);
        put_nib(start, (mode == 4'hC), r);
        for (int b = 0; b < 3; b++) begin
            logic rb;
            put_bit(v[b], rb);
        end
        host_sck = 1'b0;
        host_din = v[3];
        t_chg = $time;
        wait_cyc(HALF);
        host_sck = 1'b1;
        host_sel = 1'b0;
        exp_oe = 1'b0;
        t_chg = $time;
        exp_desel++;
        wait_cyc(10);
        host_sck = 1'b0;
        t_chg = $time;
        wait_cyc(10);
    endtask

    task automatic cmp_mem(input string req);
        for (int i = 0; i < 16; i++)
            chk($sformatf("%s mem[%0h]", req, i), mem[i], exp_mem[i]);
    endtask

    initial begin
        int bad_total;
        for (int i = 0; i < 16; i++) exp_mem[i] = 4'(i * 5 + 2);
        repeat (3) @(negedge clk);
        chk("R10 doe in reset", host_doe, 0);
        chk("R10 we in reset", rf_we, 0);
        wait_cyc(2);
        rst = 1'b0;
        t_chg = $time;
        wait_cyc(3);
        @(negedge clk);
        chk("R10 doe after reset", host_doe, 0);
        chk("R10 irq strobe after reset", irqf_clear, 0);
        chk("R10 desel after reset", desel_pulse, 0);
        wait_cyc(4);

        // R1: plain write burst
        tx[0] = 4'hA; tx[1] = 4'h5; tx[2] = 4'hC;
        txn(4'h3, 4'h2, 3, 0);
        cmp_mem("R1");
        // R3: read back
        txn(4'hC, 4'h2, 3, 0);
        // R2: write burst crossing F to 0
        tx[0] = 4'h1; tx[1] = 4'h9; tx[2] = 4'h6; tx[3] = 4'h0;
        txn(4'h3, 4'hE, 4, 0);
        cmp_mem("R2 wrap write");
        txn(4'hC, 4'hF, 3, 0);
        // R9: write all ones to the flag register, flag bit must survive
        tx[0] = 4'hF;
        txn(4'h3, 4'hD, 1, 0);
        cmp_mem("R9 mask");
        tx[0] = 4'h0;
        txn(4'h3, 4'hD, 1, 0);
        cmp_mem("R9 mask clear");
        // R8: reads touching 0xD
        txn(4'hC, 4'hD, 1, 0);
        txn(4'hC, 4'hC, 3, 0);
        chk("R8 irq clear count", n_irq, exp_irq);
        // R5: partial nibble after a good one
        tx[0] = 4'h7; tx[1] = 4'hF;
        txn(4'h3, 4'h5, 1, 2);
        cmp_mem("R5 partial write");
        chk("R5 write count", n_we, exp_we);
        // R8: partial read of 0xD
        tx[0] = 4'h0;
        txn(4'hC, 4'hD, 0, 3);
        chk("R8 partial read no clear", n_irq, exp_irq);
        // R4: unknown mode codes
        tx[0] = 4'h8; tx[1] = 4'h3; tx[2] = 4'hC;
        txn(4'h5, 4'h0, 3, 0);
        txn(4'h0, 4'h3, 3, 0);
        cmp_mem("R4 bad mode");
        chk("R4 write count", n_we, exp_we);
        // R6: clock toggling with select low
        for (int i = 0; i < 8; i++) begin
            logic rb;
            put_bit(1'b1, rb);
            chk("R6 dout idle", rb, 0);
        end
        host_sck = 1'b0;
        t_chg = $time;
        wait_cyc(10);
        chk("R6 write count", n_we, exp_we);
        cmp_mem("R6");
        // R5/R8: edge and deselect in the same cycle
        race(4'h3, 4'h4, 4'hF);
        cmp_mem("R5 race write");
        chk("R5 race write count", n_we, exp_we);
        race(4'hC, 4'hD, 4'h0);
        chk("R8 race read no clear", n_irq, exp_irq);
        // Closing strobe totals
        chk("R7 desel pulses", n_desel, exp_desel);
        chk("R8 irq clear total", n_irq, exp_irq);
        chk("R1 write total", n_we, exp_we);

        finished = 1'b1;
        bad_total = bad + oe_bad;
        $display("test done: total=%0d bad=%0d", checks + oe_checks, bad_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", checks + oe_checks + 1, bad + oe_bad + 1);
            $finish;
        end
    end

endmodule